// File: doc/BRIEF.md
# Interleaved Fractional Bit-Clock Divider

This block makes the bit-master clock for a serial-audio transmitter. It divides a source clock by a ratio N + b/a that need not be an integer. Each output period lasts either N or N+1 source ticks. In every group of a consecutive periods, b periods are long and a − b are short. The long and short periods are placed in a fixed nested order so that they stay spread out.

Four candidate sources reach the block as tick strobes at the rate of a single fast clock. A 2-bit code picks the strobe that drives the divider. A gate enable freezes the divider and silences its outputs. A module-active enable returns the divider to idle, and the next group then starts fresh. The outputs are the divided clock and a one-cycle pulse at the start of every output period. The divisor, the denominator and the numerator are taken in only at group boundaries.

Top module: `bclk_frac_div`

## Requirements
- R1: With select code k (0 to 3), only `src_tick_i[k]` advances the divider. Strobes on the other three lines have no effect on the outputs.
- R2: In fractional mode (0 < b < a), each group of a periods contains exactly b periods of N+1 ticks and a − b periods of N ticks, so the group lasts a·N + b ticks.
- R3: When 2b ≤ a, a group is b repetitions of [x periods of N, then one of N+1], followed by y periods of N, with x = ⌊(a−b)/b⌋ and y = (a−b) − b·x.
- R4: When 2b > a, a group is (a−b) repetitions of [one period of N, then x periods of N+1], followed by y periods of N+1, with x = ⌊b/(a−b)⌋ and y = b − (a−b)·x.
- R5: When b = 0, a = 0 or b ≥ a, every period lasts N ticks.
- R6: A divisor N of 0 or 1 acts as 2.
- R7: `edge_o` is high for exactly one clock cycle at the first tick of each period, and `bclk_o` is high together with it. `bclk_o` stays high for ⌊L/2⌋ ticks of a period of L ticks and is low for the rest.
- R8: While `gate_en_i` is 0, `bclk_o` and `edge_o` are 0 and the divider holds its position. When the gate opens again, the interrupted period completes with its remaining ticks.
- R9: While `active_i` is 0, `bclk_o` and `edge_o` are 0. After `active_i` rises again, the first selected tick starts a new group from its first period, and `edge_o` is seen in the cycle after that tick.
- R10: A change of N, a or b during a group takes effect at the first period of the next group.
- R11: While reset is asserted and after it is released, `bclk_o` and `edge_o` are 0 until the first selected tick arrives with both enables set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock; all source strobes are synchronous to it |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_sel_i | input | 2 | Source select code |
| src_tick_i | input | 4 | One tick strobe per candidate source |
| gate_en_i | input | 1 | Clock-gate enable; 0 freezes the divider and forces the outputs low |
| active_i | input | 1 | Module-active enable; 0 returns the divider to idle |
| div_n_i | input | 8 | Integer divisor N |
| den_a_i | input | 6 | Fraction denominator a |
| num_b_i | input | 6 | Fraction numerator b |
| bclk_o | output | 1 | Divided bit clock |
| edge_o | output | 1 | One-cycle pulse at the start of each output period |

## Verification
The period lengths are measured in selected ticks, so the ticks can arrive sparsely or at random. Directed ratios with 2b ≤ a and with 2b > a tell the two nested orders apart. The integer-mode settings (b = 0, b = a, a = 0) and divisors below 2 cover the clamping and degenerate paths. Random ratios add noise on the unselected strobe lines, which separates a correct select from one that listens to the wrong line.

A ratio change made mid-group shows whether the new setting waits for the group boundary. A gate pause in the middle of a period tells a freeze from a restart. Dropping the module-active enable in mid-group tells a restart from a resume.

// File: rtl/bclk_pkg.sv
package bclk_pkg;
  parameter int unsigned DIV_W  = 8;
  parameter int unsigned FRAC_W = 6;
  parameter int unsigned N_SRC  = 4;
  localparam int unsigned SRC_W = $clog2(N_SRC);
  localparam int unsigned LEN_W = DIV_W + 1;

  // Pattern description for one group of output periods.
  typedef struct packed {
    logic [DIV_W-1:0]  base;        // clamped short length N
    logic [FRAC_W-1:0] reps;        // z: repetitions of the nested unit
    logic [FRAC_W-1:0] run;         // x: majority periods inside one unit
    logic [FRAC_W-1:0] tail;        // y: trailing majority periods
    logic              long_major;  // majority periods are the long ones
  } pat_cfg_t;
endpackage

// File: rtl/bclk_src_pick.sv
module bclk_src_pick
  import bclk_pkg::*;
(
  input  logic [SRC_W-1:0] sel_i,
  input  logic [N_SRC-1:0] tick_i,
  output logic             tick_o
);
  logic [N_SRC-1:0] hit;

  for (genvar k = 0; k < N_SRC; k++) begin : g_dec
    assign hit[k] = tick_i[k] && (sel_i == SRC_W'(k));
  end

  assign tick_o = |hit;
endmodule

// File: rtl/bclk_pat_cfg.sv
module bclk_pat_cfg
  import bclk_pkg::*;
(
  input  logic [DIV_W-1:0]  div_i,
  input  logic [FRAC_W-1:0] den_i,
  input  logic [FRAC_W-1:0] num_i,
  output pat_cfg_t          cfg_o
);
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

  logic              frac_on;
  logic              upper_half;
  logic [FRAC_W-1:0] short_cnt;
  logic [FRAC_W-1:0] minor;
  logic [FRAC_W-1:0] major;
  logic [FRAC_W-1:0] run_v;

  always_comb begin
    cfg_o      = '0;
    cfg_o.base = (div_i < MIN_DIV) ? MIN_DIV : div_i;
    frac_on    = (num_i != '0) && (num_i < den_i);
    short_cnt  = den_i - num_i;
    // 2b > a selects the mirrored arrangement
    upper_half = ({1'b0, num_i} << 1) > {1'b0, den_i};
    minor      = upper_half ? short_cnt : num_i;
    major      = upper_half ? num_i : short_cnt;
    run_v      = '0;
    if (frac_on) begin
      run_v            = major / minor;
      cfg_o.reps       = minor;
      cfg_o.run        = run_v;
      cfg_o.tail       = major - minor * run_v;
      cfg_o.long_major = upper_half;
    end else begin
      // integer mode: a group of one short period
      cfg_o.reps       = '0;
      cfg_o.run        = '0;
      cfg_o.tail       = FRAC_W'(1);
      cfg_o.long_major = 1'b0;
    end
  end
endmodule

// File: rtl/bclk_pat_seq.sv
module bclk_pat_seq
  import bclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             adv_i,
  input  pat_cfg_t         cfg_new_i,
  output logic [LEN_W-1:0] len_o
);
  localparam logic [FRAC_W-1:0] F_ONE = FRAC_W'(1);

  pat_cfg_t          cfg_q, cfg_d, cfg_use;
  logic              start_q, start_d;
  logic              in_tail_q, in_tail_d, in_tail_c;
  logic [FRAC_W-1:0] rep_q, rep_d, rep_c;
  logic [FRAC_W-1:0] elem_q, elem_d, elem_c;
  logic [FRAC_W-1:0] tail_q, tail_d, tail_c;
  logic              minor_pick, long_pick;

  // Position of the period that starts on the next advance.
  always_comb begin
    cfg_use   = start_q ? cfg_new_i : cfg_q;
    in_tail_c = start_q ? (cfg_use.reps == '0) : in_tail_q;
    rep_c     = start_q ? '0 : rep_q;
    elem_c    = start_q ? '0 : elem_q;
    tail_c    = start_q ? '0 : tail_q;
    if (in_tail_c)
      minor_pick = 1'b0;
    else if (cfg_use.long_major)
      minor_pick = (elem_c == '0);
    else
      minor_pick = (elem_c == cfg_use.run);
    long_pick = minor_pick ^ cfg_use.long_major;
    len_o     = {1'b0, cfg_use.base} + LEN_W'(long_pick);
  end

  // Next-state: step through units, then the tail, then wrap.
  always_comb begin
    cfg_d     = cfg_q;
    start_d   = start_q;
    in_tail_d = in_tail_q;
    rep_d     = rep_q;
    elem_d    = elem_q;
    tail_d    = tail_q;
    if (clear_i) begin
      start_d   = 1'b1;
      in_tail_d = 1'b0;
      rep_d     = '0;
      elem_d    = '0;
      tail_d    = '0;
    end else if (adv_i) begin
      cfg_d     = cfg_use;
      start_d   = 1'b0;
      in_tail_d = in_tail_c;
      rep_d     = rep_c;
      elem_d    = elem_c;
      tail_d    = tail_c;
      if (in_tail_c) begin
        if (tail_c == cfg_use.tail - F_ONE) start_d = 1'b1;
        else tail_d = tail_c + F_ONE;
      end else if (elem_c == cfg_use.run) begin
        elem_d = '0;
        if (rep_c == cfg_use.reps - F_ONE) begin
          rep_d = '0;
          if (cfg_use.tail == '0) begin
            start_d = 1'b1;
          end else begin
            in_tail_d = 1'b1;
            tail_d    = '0;
          end
        end else begin
          rep_d = rep_c + F_ONE;
        end
      end else begin
        elem_d = elem_c + F_ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      start_q   <= 1'b1;
      in_tail_q <= 1'b0;
      rep_q     <= '0;
      elem_q    <= '0;
      tail_q    <= '0;
    end else if (clear_i || adv_i) begin
      cfg_q     <= cfg_d;
      start_q   <= start_d;
      in_tail_q <= in_tail_d;
      rep_q     <= rep_d;
      elem_q    <= elem_d;
      tail_q    <= tail_d;
    end
  end

  // R10: the latched pattern only moves when a period starts
  a_r10_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(cfg_q));
  // R2: the tail index stays within the tail length
  a_r2_tail_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_q && in_tail_q) |-> (tail_q < cfg_q.tail));
  // R3 / R4: unit counters stay inside the unit and repetition counts
  a_r3_unit_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_q && !in_tail_q) |-> ((elem_q <= cfg_q.run) && (rep_q < cfg_q.reps)));
endmodule

// File: rtl/bclk_period.sv
module bclk_period
  import bclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             start_o,
  output logic             clk_o,
  output logic             edge_o
);
  localparam logic [LEN_W-1:0] L_ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0] L_MIN = LEN_W'(2);

  logic             run_q, run_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             clk_q, clk_d;
  logic             edge_q, edge_d;

  always_comb begin
    start_o = tick_i && (!run_q || (cnt_q == len_q - L_ONE));
    run_d   = run_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    edge_d  = 1'b0;
    if (clear_i) begin
      run_d = 1'b0;
      cnt_d = '0;
      len_d = '0;
    end else if (tick_i) begin
      run_d = 1'b1;
      if (start_o) begin
        cnt_d = '0;
        len_d = len_i;
      end else begin
        cnt_d = cnt_q + L_ONE;
      end
      edge_d = start_o;
    end
    clk_d = run_d && (cnt_d < (len_d >> 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      len_q  <= '0;
      clk_q  <= 1'b0;
      edge_q <= 1'b0;
    end else if (clear_i || tick_i || edge_q) begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      clk_q  <= clk_d;
      edge_q <= edge_d;
    end
  end

  assign clk_o  = clk_q;
  assign edge_o = edge_q;

  // R7: the period pulse lasts one cycle and coincides with the high phase
  a_r7_edge_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_q |=> !edge_q);
  a_r7_edge_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_q |-> clk_q);
  // R6: no running period is shorter than two ticks
  a_r6_len_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (len_q >= L_MIN));
  // R8: without a tick the divider holds its place
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clear_i) |=> ($stable(cnt_q) && $stable(clk_q) && !edge_q));
  // R9: leaving the active state returns to idle
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!run_q && !clk_q));
endmodule

// File: rtl/bclk_frac_div.sv
module bclk_frac_div
  import bclk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SRC_W-1:0]  src_sel_i,
  input  logic [N_SRC-1:0]  src_tick_i,
  input  logic              gate_en_i,
  input  logic              active_i,
  input  logic [DIV_W-1:0]  div_n_i,
  input  logic [FRAC_W-1:0] den_a_i,
  input  logic [FRAC_W-1:0] num_b_i,
  output logic              bclk_o,
  output logic              edge_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  logic             tick_sel;
  logic             tick_run;
  logic             clear;
  logic             start;
  logic             clk_raw;
  logic             edge_raw;
  logic [LEN_W-1:0] next_len;
  pat_cfg_t         cfg_live;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  bclk_src_pick u_pick (
    .sel_i  (src_sel_i),
    .tick_i (src_tick_i),
    .tick_o (tick_sel)
  );

  assign clear    = !active_i;
  assign tick_run = active_i && gate_en_i && tick_sel;

  bclk_pat_cfg u_cfg (
    .div_i (div_n_i),
    .den_i (den_a_i),
    .num_i (num_b_i),
    .cfg_o (cfg_live)
  );

  bclk_pat_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .clear_i   (clear),
    .adv_i     (start),
    .cfg_new_i (cfg_live),
    .len_o     (next_len)
  );

  bclk_period u_per (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .clear_i (clear),
    .tick_i  (tick_run),
    .len_i   (next_len),
    .start_o (start),
    .clk_o   (clk_raw),
    .edge_o  (edge_raw)
  );

  assign bclk_o = clk_raw && gate_en_i && active_i;
  assign edge_o = edge_raw && gate_en_i && active_i;

  // R1: with no selected tick the divider outputs do not start a period
  a_r1_no_foreign_edge: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (!tick_sel && !edge_raw) |=> !edge_raw);
endmodule

// File: tb/bclk_frac_div_tb_top.sv
`timescale 1ns/1ps
module bclk_frac_div_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] sel;
  logic [3:0] tick;
  logic       gate;
  logic       act;
  logic [7:0] dn;
  logic [5:0] da;
  logic [5:0] db;
  logic       bclk;
  logic       edg;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  int exp_l [0:63];
  int m_len [0:255];
  int m_hi  [0:255];
  bit m_ok;

  always #2.5 clk = ~clk;

  bclk_frac_div dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .src_sel_i  (sel),
    .src_tick_i (tick),
    .gate_en_i  (gate),
    .active_i   (act),
    .div_n_i    (dn),
    .den_a_i    (da),
    .num_b_i    (db),
    .bclk_o     (bclk),
    .edge_o     (edg)
  );

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  // Expected period lengths of one group, built from R3/R4/R5/R6.
  function automatic int build_model(input int n, input int a, input int b);
    int ne;
    int g;
    int x;
    int y;
    ne = (n < 2) ? 2 : n;
    g  = 0;
    if (a == 0 || b == 0 || b >= a) begin
      exp_l[0] = ne;
      return 1;
    end
    if (2 * b <= a) begin
      x = (a - b) / b;
      y = (a - b) - b * x;
      for (int r = 0; r < b; r++) begin
        for (int k = 0; k < x; k++) begin exp_l[g] = ne; g++; end
        exp_l[g] = ne + 1; g++;
      end
      for (int k = 0; k < y; k++) begin exp_l[g] = ne; g++; end
    end else begin
      x = b / (a - b);
      y = b - (a - b) * x;
      for (int r = 0; r < a - b; r++) begin
        exp_l[g] = ne; g++;
        for (int k = 0; k < x; k++) begin exp_l[g] = ne + 1; g++; end
      end
      for (int k = 0; k < y; k++) begin exp_l[g] = ne + 1; g++; end
    end
    return g;
  endfunction

  // Measure np periods in selected ticks; noise on the other strobe lines.
  task automatic measure(input int s, input int dens, input int np,
                         input int sw_at, input int sn, input int sa, input int sb);
    int  tc;
    int  last;
    int  hi;
    int  ne;
    bit  t;
    bit  switched;
    logic [3:0] noise;
    tc = 0; last = 0; hi = 0; ne = 0; switched = 1'b0;
    m_ok = 1'b0;
    for (int cyc = 0; cyc < 20000; cyc++) begin
      @(negedge clk);
      if (edg) begin
        if (ne > 0) begin
          m_len[ne-1] = tc - last;
          m_hi[ne-1]  = hi;
        end
        last = tc;
        hi   = 0;
        ne++;
      end
      if (ne > np) begin
        m_ok = 1'b1;
        break;
      end
      if (!switched && sw_at >= 0 && ne == sw_at) begin
        dn = 8'(sn); da = 6'(sa); db = 6'(sb);
        switched = 1'b1;
      end
      t     = ($urandom_range(99) < dens);
      noise = 4'($urandom_range(15));
      noise[s] = t;
      tick  = noise;
      if (t) begin
        tc++;
        if (bclk) hi++;
      end
    end
    tick = 4'b0;
  endtask

  task automatic cmp_seq(input string tag, input int np, input int g);
    int bad;
    int hbad;
    bad = -1; hbad = -1;
    for (int i = 0; i < np; i++) begin
      if (bad < 0 && m_len[i] != exp_l[i % g]) bad = i;
      if (hbad < 0 && m_hi[i] != m_len[i] / 2) hbad = i;
    end
    if (bad < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, tag, m_len[bad], exp_l[bad % g]);
    if (hbad < 0) chk(1'b1, "R7 high phase", 0, 0);
    else chk(1'b0, "R7 high phase", m_hi[hbad], m_len[hbad] / 2);
  endtask

  task automatic run_cfg(input string tag, input int n, input int a, input int b,
                         input int s, input int dens, input int groups);
    int g;
    int sum;
    int longs;
    int ne;
    g = build_model(n, a, b);
    ne = (n < 2) ? 2 : n;
    act = 1'b0; tick = 4'b0;
    dn = 8'(n); da = 6'(a); db = 6'(b); sel = 2'(s);
    repeat (2) @(negedge clk);
    act = 1'b1;
    measure(s, dens, g * groups, -1, 0, 0, 0);
    chk(m_ok, {tag, " periods seen"}, 0, 1);
    cmp_seq(tag, g * groups, g);
    if (b > 0 && b < a) begin
      sum = 0; longs = 0;
      for (int i = 0; i < a; i++) begin
        sum += m_len[i];
        if (m_len[i] == ne + 1) longs++;
      end
      chk(sum == a * ne + b && longs == b, "R2 group totals", sum, a * ne + b);
    end
  endtask

  initial begin
    #750000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int cnt;
    int n;
    int a;
    int b;
    void'($urandom(32'd7341));
    rst_n = 1'b0; act = 1'b0; gate = 1'b1; tick = 4'b0; sel = 2'd0;
    dn = 8'd4; da = 6'd1; db = 6'd0;
    repeat (3) @(negedge clk);
    chk(!bclk && !edg, "R11 in reset", int'(bclk), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!bclk && !edg, "R11 after release", int'(bclk), 0);

    // R1: foreign strobes only
    sel = 2'd2; act = 1'b1; cnt = 0;
    for (int i = 0; i < 20; i++) begin
      tick = 4'b1011;
      @(negedge clk);
      if (bclk || edg) cnt++;
    end
    tick = 4'b0;
    chk(cnt == 0, "R1 unselected lines ignored", cnt, 0);
    for (int s = 0; s < 4; s++) run_cfg("R1 select", 4, 1, 0, s, 60, 3);

    // R3 / R4 / R5 / R6 directed
    run_cfg("R3 low fraction", 3, 5, 2, 0, 100, 2);
    run_cfg("R3 sparse", 5, 12, 5, 1, 40, 2);
    run_cfg("R4 high fraction", 4, 5, 4, 2, 100, 2);
    run_cfg("R4 mixed tail", 6, 7, 5, 3, 70, 2);
    run_cfg("R5 b equals a", 5, 3, 3, 0, 100, 4);
    run_cfg("R5 zero denominator", 3, 0, 1, 1, 100, 4);
    run_cfg("R6 divisor one", 1, 1, 0, 0, 100, 4);
    run_cfg("R6 divisor zero", 0, 2, 1, 2, 100, 4);

    // R10: change mid-group, applies after the group
    act = 1'b0; dn = 8'd3; da = 6'd5; db = 6'd2; sel = 2'd0;
    repeat (2) @(negedge clk);
    act = 1'b1;
    measure(0, 100, 8, 2, 6, 1, 0);
    exp_l[0] = 3; exp_l[1] = 4; exp_l[2] = 3; exp_l[3] = 4; exp_l[4] = 3;
    exp_l[5] = 6; exp_l[6] = 6; exp_l[7] = 6;
    chk(m_ok, "R10 periods seen", 0, 1);
    cmp_seq("R10 latch at group end", 8, 64);

    // R9 latency and R8 gate freeze, integer N = 6
    act = 1'b0; dn = 8'd6; da = 6'd1; db = 6'd0; sel = 2'd3;
    repeat (2) @(negedge clk);
    act = 1'b1; tick = 4'b1000;
    @(negedge clk);
    chk(edg && bclk, "R9 first tick starts period", int'(edg), 1);
    repeat (2) @(negedge clk);
    gate = 1'b0; cnt = 0;
    for (int i = 0; i < 10; i++) begin
      tick = 4'($urandom_range(15)) | 4'b1000;
      @(negedge clk);
      if (bclk || edg) cnt++;
    end
    chk(cnt == 0, "R8 outputs quiet while gated", cnt, 0);
    gate = 1'b1; tick = 4'b1000; cnt = 0;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (edg && cnt == 0) cnt = i;
    end
    chk(cnt == 4, "R8 period resumes", cnt, 4);
    tick = 4'b0;

    // R9: drop active mid-group, restart from group start
    act = 1'b0; dn = 8'd3; da = 6'd5; db = 6'd2; sel = 2'd1;
    repeat (2) @(negedge clk);
    act = 1'b1;
    measure(1, 100, 2, -1, 0, 0, 0);
    act = 1'b0; cnt = 0;
    for (int i = 0; i < 3; i++) begin
      tick = 4'b0010;
      @(negedge clk);
      if (bclk || edg) cnt++;
    end
    chk(cnt == 0, "R9 outputs quiet while inactive", cnt, 0);
    tick = 4'b0; act = 1'b1;
    measure(1, 100, 5, -1, 0, 0, 0);
    void'(build_model(3, 5, 2));
    chk(m_ok, "R9 periods seen", 0, 1);
    cmp_seq("R9 restart at group start", 5, 5);

    // random ratios
    for (int k = 0; k < 10; k++) begin
      n = $urandom_range(9);
      a = $urandom_range(12);
      b = $urandom_range(a + 1);
      if (b > 0 && b < a) begin
        if (2 * b <= a) run_cfg("R3 random", n, a, b, $urandom_range(3), 75, 2);
        else run_cfg("R4 random", n, a, b, $urandom_range(3), 75, 2);
      end else begin
        run_cfg("R5 random", n, a, b, $urandom_range(3), 75, 3);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule